// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block performs integer division and remainder for a 64-bit datapath, one operation at a time. A single start pulse hands it two operands, A as the dividend and B as the divisor, along with an operation selection. The selection chooses word or doubleword width, signed or unsigned arithmetic, and one of three kinds: a plain divide, an extended divide whose dividend is A shifted up by the operand width, or a remainder. The unit produces one quotient bit per clock with a radix-2 restoring divider that works on magnitudes. It applies the sign afterwards.

Every corner case has a defined result. A divide whose quotient cannot be represented returns zero and reports overflow. This covers a zero divisor, the most negative value divided by -1, and an extended quotient wider than the operand. A remainder with a zero divisor, or in the signed -1 case, returns zero. Two request bits choose what is written back. One asks for the overflow flags; the summary-overflow flag is sticky across operations. The other asks for a 4-bit sign/zero condition field for the result.

The caller holds the operands until the start edge and then waits for the one-cycle done pulse. The result, flags and condition field stay on the outputs until the next completion.

Top module: `intdiv_unit`

## Requirements
- R1: While reset is high, and after it is released, `busy`, `done`, `result`, `so_out`, `ov_out`, `ov32_out` and `cr_out` are all zero.
- R2: A start sampled while idle is accepted, and `busy` is high from the next cycle. `done` is high for exactly one cycle, on the (N+1)-th rising edge after the accepting edge, where N is 32 for word and 64 for doubleword operations. `busy` is low while `done` is high. A start sampled while busy is ignored. `result` changes only together with `done`.
- R3: `op_kind`=00 is a plain divide and truncates toward zero. `op_signed`=1 selects two's-complement operands and `op_word`=1 selects word width. Word operations read only bits 31:0 of each operand. A word quotient is returned zero-extended in bits 63:32, for signed operations as well.
- R4: `op_kind`=01 is an extended divide. Its dividend is A at the operation width, placed above as many zero bits as the width, and B is sign- or zero-extended as the signedness requires.
- R5: A divide with a zero divisor, or a signed divide of the most negative value of the width by -1, overflows and returns zero.
- R6: An extended divide whose true quotient does not fit the width overflows and returns zero. The fitting range is the signed range for signed operations and the unsigned range otherwise.
- R7: `op_kind`=10 or 11 returns the remainder, which carries the sign of the dividend. A signed word remainder is sign-extended to 64 bits; an unsigned word remainder is zero-extended. The remainder is zero when the divisor is zero or, for signed operations, when the divisor is -1. A remainder operation never reports overflow.
- R8: When `ov_req` is set for a divide, `ov_out` and `ov32_out` both take that operation's overflow value, and `so_out` becomes `so_in` OR that overflow. Otherwise `ov_out` and `ov32_out` keep their values and `so_out` becomes `so_in`.
- R9: When `cr_req` is set, `cr_out` takes LT in bit 3, GT in bit 2, EQ in bit 1 and SO in bit 0. LT, GT and EQ come from comparing the result, read as signed at the operation width, with zero. Without `cr_req`, `cr_out` keeps its value.
- R10: The SO bit of `cr_out` equals the `so_out` value written by the same operation. With `cr_req` set but no flag update, it is therefore `so_in`.
- R11: The operands, operation selection, `ov_req`, `cr_req` and `so_in` are sampled only on the accepting edge. Changing them afterwards has no effect on the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_kind | input | 2 | 00 divide, 01 extended divide, 10/11 remainder |
| op_signed | input | 1 | Signed operands when set |
| op_word | input | 1 | 32-bit operation when set |
| ov_req | input | 1 | Write the overflow flags |
| cr_req | input | 1 | Write the condition field |
| so_in | input | 1 | Incoming sticky summary-overflow |
| opnd_a | input | 64 | Dividend operand |
| opnd_b | input | 64 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder |
| so_out | output | 1 | Summary-overflow |
| ov_out | output | 1 | Overflow |
| ov32_out | output | 1 | 32-bit overflow |
| cr_out | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `rst` is applied for at least one clock before any start. They also assume that `op_word` is stable in the cycle start is accepted, because the latency check fixes the iteration count from that sample. The stimulus drives every input at the falling edge. It raises start only after completion, except for a deliberate start during a busy period, which the unit must ignore. It also changes every operation input right after the accepting edge, to show that only sampled values count. The operand set covers zero, ±1, the extremes of both widths and values with junk in the upper word.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        KIND_DIV     = 2'b00,
        KIND_DIV_EXT = 2'b01,
        KIND_REM     = 2'b10,
        KIND_REM_ALT = 2'b11
    } div_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } div_state_e;

    // Everything the post-processing stage needs to fix up the magnitudes.
    typedef struct packed {
        logic is_rem;
        logic sgn;
        logic word;
        logic neg_q;
        logic neg_r;
        logic div0;
        logic m1min;
        logic mag_ovf;
    } arith_ctl_t;

    // Write-back requests captured with the operation.
    typedef struct packed {
        logic ov_req;
        logic cr_req;
        logic so_in;
    } flag_req_t;

    // Returns {lt, gt, eq} for a value described by its sign and zero test.
    function automatic logic [2:0] sign_class(input logic neg, input logic zero);
        return {neg, !neg && !zero, zero};
    endfunction

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]                   op_kind,
    input  logic                         op_signed,
    input  logic                         op_word,
    input  logic [XLEN-1:0]              opnd_a,
    input  logic [XLEN-1:0]              opnd_b,
    output arith_ctl_t                   ctl,
    output logic [XLEN-1:0]              rem_init,
    output logic [XLEN-1:0]              low_init,
    output logic [XLEN-1:0]              dvs_mag,
    output logic [$clog2(XLEN+1)-1:0]    iters
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);

    div_kind_e       kind;
    logic            is_ext;
    logic [XLEN-1:0] a_ext, b_ext, a_mag;
    logic            a_neg, b_neg, a_is_min, b_all1;

    assign kind   = div_kind_e'(op_kind);
    assign is_ext = (kind == KIND_DIV_EXT);

    // Width selection with sign or zero extension of the low half.
    always_comb begin
        if (op_word) begin
            a_ext = op_signed ? {{HALF{opnd_a[HALF-1]}}, opnd_a[HALF-1:0]}
                              : {{HALF{1'b0}}, opnd_a[HALF-1:0]};
            b_ext = op_signed ? {{HALF{opnd_b[HALF-1]}}, opnd_b[HALF-1:0]}
                              : {{HALF{1'b0}}, opnd_b[HALF-1:0]};
            a_neg    = op_signed & opnd_a[HALF-1];
            b_neg    = op_signed & opnd_b[HALF-1];
            a_is_min = (opnd_a[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}});
            b_all1   = &opnd_b[HALF-1:0];
        end else begin
            a_ext    = opnd_a;
            b_ext    = opnd_b;
            a_neg    = op_signed & opnd_a[XLEN-1];
            b_neg    = op_signed & opnd_b[XLEN-1];
            a_is_min = (opnd_a == {1'b1, {(XLEN-1){1'b0}}});
            b_all1   = &opnd_b;
        end
    end

    assign a_mag   = a_neg ? (~a_ext + 1'b1) : a_ext;
    assign dvs_mag = b_neg ? (~b_ext + 1'b1) : b_ext;

    // Extended forms start with the dividend in the upper half of the
    // double-width shift register; plain forms start it in the lower half,
    // left-aligned so that word operations finish after HALF shifts.
    always_comb begin
        if (is_ext) begin
            rem_init = a_mag;
            low_init = '0;
        end else begin
            rem_init = '0;
            low_init = op_word ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
        end
    end

    assign iters = op_word ? CW'(HALF) : CW'(XLEN);

    always_comb begin
        ctl         = '0;
        ctl.is_rem  = (kind == KIND_REM) || (kind == KIND_REM_ALT);
        ctl.sgn     = op_signed;
        ctl.word    = op_word;
        ctl.neg_q   = a_neg ^ b_neg;
        ctl.neg_r   = a_neg;
        ctl.div0    = (b_ext == '0);
        ctl.m1min   = op_signed & b_all1 & a_is_min;
        // Upper half not below the divisor: quotient exceeds the width.
        ctl.mag_ovf = is_ext & (rem_init >= dvs_mag);
    end

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] rem_init,
    input  logic [XLEN-1:0] low_init,
    input  logic [XLEN-1:0] dvs_in,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    logic [XLEN-1:0] rem_q, low_q, dvs_q;
    logic [XLEN:0]   shifted;
    logic [XLEN+1:0] trial;
    logic            fits;

    // One restoring step: bring in the next dividend bit, try to subtract.
    assign shifted = {rem_q, low_q[XLEN-1]};
    assign trial   = {1'b0, shifted} - {2'b00, dvs_q};
    assign fits    = !trial[XLEN+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            low_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= rem_init;
            low_q <= low_init;
            dvs_q <= dvs_in;
        end else if (step) begin
            rem_q <= fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
            low_q <= {low_q[XLEN-2:0], fits};
        end
    end

    assign quo = low_q;
    assign rem = rem_q;

endmodule

// File: rtl/intdiv_post.sv
module intdiv_post
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  arith_ctl_t      ctl,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic [2:0]      cmp
);
    localparam int HALF = XLEN / 2;

    logic            q_top, q_low_nz, sgn_ovf;
    logic [XLEN-1:0] q_val, q_res, r_val, r_res;
    logic            res_neg, res_zero;

    always_comb begin
        q_top    = ctl.word ? quo[HALF-1] : quo[XLEN-1];
        q_low_nz = ctl.word ? |quo[HALF-2:0] : |quo[XLEN-2:0];
    end

    // A signed quotient magnitude may reach 2^(w-1) only when negative.
    assign sgn_ovf = ctl.sgn & q_top & (!ctl.neg_q | q_low_nz);
    assign ovf     = !ctl.is_rem & (ctl.mag_ovf | ctl.div0 | sgn_ovf);

    assign q_val = ctl.neg_q ? (~quo + 1'b1) : quo;
    assign q_res = ctl.word ? {{HALF{1'b0}}, q_val[HALF-1:0]} : q_val;

    assign r_val = ctl.neg_r ? (~rem + 1'b1) : rem;
    always_comb begin
        if (ctl.div0 || ctl.m1min) begin
            r_res = '0;
        end else if (ctl.word) begin
            r_res = ctl.sgn ? {{HALF{r_val[HALF-1]}}, r_val[HALF-1:0]}
                            : {{HALF{1'b0}}, r_val[HALF-1:0]};
        end else begin
            r_res = r_val;
        end
    end

    assign result = ctl.is_rem ? r_res : (ovf ? '0 : q_res);

    always_comb begin
        res_neg  = ctl.word ? result[HALF-1] : result[XLEN-1];
        res_zero = ctl.word ? (result[HALF-1:0] == '0) : (result == '0);
    end

    assign cmp = sign_class(res_neg, res_zero);

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op_kind,
    input  logic            op_signed,
    input  logic            op_word,
    input  logic            ov_req,
    input  logic            cr_req,
    input  logic            so_in,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            so_out,
    output logic            ov_out,
    output logic            ov32_out,
    output logic [3:0]      cr_out
);
    localparam int CW = $clog2(XLEN + 1);

    div_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    arith_ctl_t      ctl_d, ctl_q;
    flag_req_t       req_q;
    logic [XLEN-1:0] rem_init, low_init, dvs_mag, quo, rem, res_d;
    logic [CW-1:0]   iters;
    logic            accept, ovf_d, flag_upd, so_new;
    logic [2:0]      cmp_d;
    logic            done_q, so_q, ov_q, ov32_q;
    logic [XLEN-1:0] result_q;
    logic [3:0]      cr_q;

    assign accept = start && (state_q == ST_IDLE);

    intdiv_prep #(.XLEN(XLEN)) u_prep (
        .op_kind   (op_kind),
        .op_signed (op_signed),
        .op_word   (op_word),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .ctl       (ctl_d),
        .rem_init  (rem_init),
        .low_init  (low_init),
        .dvs_mag   (dvs_mag),
        .iters     (iters)
    );

    intdiv_core #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (state_q == ST_RUN),
        .rem_init (rem_init),
        .low_init (low_init),
        .dvs_in   (dvs_mag),
        .quo      (quo),
        .rem      (rem)
    );

    intdiv_post #(.XLEN(XLEN)) u_post (
        .ctl    (ctl_q),
        .quo    (quo),
        .rem    (rem),
        .result (res_d),
        .ovf    (ovf_d),
        .cmp    (cmp_d)
    );

    assign flag_upd = req_q.ov_req & !ctl_q.is_rem;
    assign so_new   = req_q.so_in | (flag_upd & ovf_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            ctl_q    <= '0;
            req_q    <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
            so_q     <= 1'b0;
            ov_q     <= 1'b0;
            ov32_q   <= 1'b0;
            cr_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q      <= ST_RUN;
                        cnt_q        <= iters;
                        ctl_q        <= ctl_d;
                        req_q.ov_req <= ov_req;
                        req_q.cr_req <= cr_req;
                        req_q.so_in  <= so_in;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q  <= ST_IDLE;
                    done_q   <= 1'b1;
                    result_q <= res_d;
                    so_q     <= so_new;
                    if (flag_upd) begin
                        ov_q   <= ovf_d;
                        ov32_q <= ovf_d;
                    end
                    if (req_q.cr_req) begin
                        cr_q <= {cmp_d, so_new};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign so_out   = so_q;
    assign ov_out   = ov_q;
    assign ov32_out = ov32_q;
    assign cr_out   = cr_q;

endmodule

// File: rtl/intdiv_chk.sv
module intdiv_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            op_word,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            so_out,
    input logic            ov_out,
    input logic            ov32_out,
    input logic [3:0]      cr_out
);
    localparam int HALF = XLEN / 2;
    localparam int RW   = $clog2(XLEN + 4) + 1;

    logic [RW-1:0] run_cnt;
    logic          run_word;

    // Counts edges since the accepting edge, avoiding a deep $past window.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            run_word <= 1'b0;
        end else if (start && !busy) begin
            run_cnt  <= RW'(1);
            run_word <= op_word;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == (run_word ? RW'(HALF + 2) : RW'(XLEN + 2))));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R8
    ov_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ov_out == ov32_out);

    // R8
    so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_out) |-> so_out);

    // R9
    cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cr_out[3:1]));

endmodule

bind intdiv_unit intdiv_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_word  (op_word),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .so_out   (so_out),
    .ov_out   (ov_out),
    .ov32_out (ov32_out),
    .cr_out   (cr_out)
);

// File: tb/tb_intdiv_unit.sv
`timescale 1ns/1ps
module tb_intdiv_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op_kind;
    logic        op_signed, op_word, ov_req, cr_req, so_in;
    logic [63:0] opnd_a, opnd_b;
    logic        busy, done, so_out, ov_out, ov32_out;
    logic [63:0] result;
    logic [3:0]  cr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Held model state (flags written back only on request).
    logic       m_ov = 0;
    logic       m_so = 0;
    logic [3:0] m_cr = 0;

    always #5 clk = ~clk;

    intdiv_unit dut (
        .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
        .op_signed(op_signed), .op_word(op_word), .ov_req(ov_req),
        .cr_req(cr_req), .so_in(so_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .result(result), .so_out(so_out),
        .ov_out(ov_out), .ov32_out(ov32_out), .cr_out(cr_out)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference on wide signed integers.
    function automatic void ref_op(input logic [1:0] k, input bit s, input bit w,
                                   input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] res, output bit ovf);
        logic signed [129:0] n, d, q, r, hi, lo;
        int wd;
        wd = w ? 32 : 64;
        if (w) begin
            n = s ? {{98{a[31]}}, a[31:0]} : {98'b0, a[31:0]};
            d = s ? {{98{b[31]}}, b[31:0]} : {98'b0, b[31:0]};
        end else begin
            n = s ? {{66{a[63]}}, a} : {66'b0, a};
            d = s ? {{66{b[63]}}, b} : {66'b0, b};
        end
        hi = s ? (130'sd1 <<< (wd - 1)) - 130'sd1 : (130'sd1 <<< wd) - 130'sd1;
        lo = s ? -(130'sd1 <<< (wd - 1)) : 130'sd0;
        ovf = 0;
        res = '0;
        if (k < 2) begin
            if (k == 1) n = n <<< wd;
            if (d == 0) begin
                ovf = 1;
            end else begin
                q = n / d;
                ovf = (q > hi) || (q < lo);
                if (!ovf) res = w ? {32'b0, q[31:0]} : q[63:0];
            end
        end else begin
            if (d == 0 || d == -130'sd1) begin
                res = '0;
            end else begin
                r = n % d;
                res = w ? (s ? {{32{r[31]}}, r[31:0]} : {32'b0, r[31:0]}) : r[63:0];
            end
        end
    endfunction

    task automatic do_op(input logic [1:0] k, input bit s, input bit w,
                         input bit ovr, input bit crr, input bit soi,
                         input logic [63:0] a, input logic [63:0] b,
                         input bit poke);
        logic [63:0] exp_res, held;
        bit ovf, lt, eq;
        int lat, want;
        string rtag;
        ref_op(k, s, w, a, b, exp_res, ovf);
        if (ovr && k < 2) begin
            m_ov = ovf;
            m_so = soi | ovf;
        end else begin
            m_so = soi;
        end
        lt = w ? exp_res[31] : exp_res[63];
        eq = w ? (exp_res[31:0] == 0) : (exp_res == 0);
        if (crr) m_cr = {lt, !lt && !eq, eq, m_so};
        want = (w ? 32 : 64) + 2;
        rtag = (k == 0) ? "R3" : (k == 1) ? "R4" : "R7";

        @(negedge clk);
        op_kind = k; op_signed = s; op_word = w;
        ov_req = ovr; cr_req = crr; so_in = soi;
        opnd_a = a; opnd_b = b; start = 1;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            // R11: disturb every operation input after the accepting edge
            if (lat == 1) begin
                op_kind = ~k; op_signed = ~s; ov_req = ~ovr; cr_req = ~crr;
                so_in = ~soi; opnd_a = ~a; opnd_b = b ^ 64'h5;
            end
            start = poke && (lat == 4);
            if (done) break;
            chk(busy === 1'b1 && done === 1'b0, "R2 busy during run", {62'b0, busy, done}, 64'h2);
            if (lat > 200) begin
                chk(0, "R2 watchdog", 64'(lat), 64'(want));
                break;
            end
        end
        start = 0;
        chk(lat == want, "R2 latency", 64'(lat), 64'(want));
        chk(busy === 1'b0, "R2 idle at done", {63'b0, busy}, 64'h0);
        chk(result === exp_res, rtag, result, exp_res);
        chk(ov_out === m_ov && ov32_out === m_ov && so_out === m_so, "R8 R11 flags",
            {61'b0, so_out, ov_out, ov32_out}, {61'b0, m_so, m_ov, m_ov});
        chk(cr_out === m_cr, "R9 R10 cond", {60'b0, cr_out}, {60'b0, m_cr});
        held = result;
        @(negedge clk);
        chk(done === 1'b0 && result === held, "R2 pulse/hold", result, held);
    endtask

    initial begin
        #1_900_000ns;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] vals [8];
        vals[0] = 64'h0;
        vals[1] = 64'h1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h8000_0000_0000_0000;
        vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[5] = 64'hABCD_0000_8000_0000;
        vals[6] = 64'h1234_5678_7FFF_FFFF;
        vals[7] = 64'h0000_0000_0000_0007;

        rst = 1; start = 0; op_kind = 0; op_signed = 0; op_word = 0;
        ov_req = 0; cr_req = 0; so_in = 0; opnd_a = 0; opnd_b = 0;
        repeat (3) @(negedge clk);
        // R1
        chk({busy, done, so_out, ov_out, ov32_out, cr_out} === 9'b0 && result === 64'b0,
            "R1 reset", result, 64'h0);
        rst = 0;
        @(negedge clk);
        chk({busy, done, so_out, ov_out, ov32_out, cr_out} === 9'b0, "R1 after release",
            {55'b0, busy, done, so_out, ov_out, ov32_out, cr_out}, 64'h0);

        // R3: signed doubleword 100 / -7
        do_op(2'b00, 1, 0, 1, 1, 0, 64'd100, -64'sd7, 0);
        chk(result === 64'hFFFF_FFFF_FFFF_FFF2, "R3 signed dword", result, 64'hFFFF_FFFF_FFFF_FFF2);
        // R3: signed word -100 / 7 with junk above, zero-extended quotient
        do_op(2'b00, 1, 1, 0, 1, 0, 64'hABCD_0000_FFFF_FF9C, 64'h9999_0000_0000_0007, 0);
        chk(result === 64'h0000_0000_FFFF_FFF2, "R3 word zext", result, 64'h0000_0000_FFFF_FFF2);
        // R4: unsigned extended 2^64 / 4
        do_op(2'b01, 0, 0, 1, 0, 0, 64'd1, 64'd4, 0);
        chk(result === 64'h4000_0000_0000_0000, "R4 ext", result, 64'h4000_0000_0000_0000);
        // R5: divide by zero
        do_op(2'b00, 0, 0, 1, 1, 0, 64'd5, 64'd0, 0);
        chk(result === 0 && ov_out === 1 && so_out === 1, "R5 div0", result, 64'h0);
        // R5: most negative / -1
        do_op(2'b00, 1, 0, 1, 0, 0, 64'h8000_0000_0000_0000, '1, 0);
        chk(result === 0 && ov_out === 1, "R5 min/-1", result, 64'h0);
        // R8: no request keeps ov, so follows so_in (0)
        do_op(2'b00, 0, 0, 0, 0, 0, 64'd9, 64'd3, 0);
        chk(ov_out === 1 && so_out === 0, "R8 hold", {62'b0, ov_out, so_out}, 64'h2);
        // R6: unsigned extended, quotient too wide
        do_op(2'b01, 0, 0, 1, 0, 0, 64'd3, 64'd3, 0);
        chk(result === 0 && ov_out === 1, "R6 ext ovf", result, 64'h0);
        // R6: signed word extended 2^32 / 2 does not fit
        do_op(2'b01, 1, 1, 1, 0, 0, 64'd1, 64'd2, 0);
        chk(result === 0 && ov_out === 1, "R6 ext signed", result, 64'h0);
        // R7: remainder -7 % 3 signed word, sign-extended, no flags
        do_op(2'b10, 1, 1, 1, 0, 0, 64'h0000_0000_FFFF_FFF9, 64'd3, 0);
        chk(result === '1 && ov_out === 1, "R7 rem sext", result, '1);
        // R10: condition without flag request takes so_in
        do_op(2'b00, 0, 0, 0, 1, 1, 64'd0, 64'd3, 0);
        chk(cr_out === 4'b0011, "R10 so_in", {60'b0, cr_out}, 64'h3);
        // R2: start while busy is ignored
        do_op(2'b11, 0, 0, 1, 1, 0, 64'd100, 64'd7, 1);
        chk(result === 64'd2, "R2 ignored start", result, 64'd2);

        for (int k = 0; k < 3; k++)
            for (int s = 0; s < 2; s++)
                for (int w = 0; w < 2; w++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            do_op(2'(k), s[0], w[0], ((i + j) % 2) == 1,
                                  ((i + j + k) % 3) != 0, ((i * j) % 5) == 0,
                                  vals[i], vals[j], 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule